// File: doc/BRIEF.md
# Three-Segment Interpolating Gamma Table

This block applies a per-channel transfer curve to red, green and blue pixel samples. Each curve is piecewise linear and is held as three nested tables of 16-bit points. The first is a very short table with single-code spacing for the darkest codes. The second covers the lowest 1/128 of the range with steps of eight codes. The third covers the whole range with steps of 1024 codes. An input picks the finest table that contains it. The block reads the two neighbouring points and blends them by the input's remaining low bits. The blended value is rounded and then limited to a per-channel ceiling value. That ceiling also acts as the point one coarse step above full scale.

Software fills the tables through a small register port. One register holds the table pointer and its auto-advance flag. Each table point then takes two consecutive writes to the data register: the upper ten bits of every channel first, then the lower six bits. Points are read back in the same two-word order. The pixel path accepts one pixel per clock, has a fixed latency and carries a valid flag alongside the data.

Top module: `gamma_mseg_lut`

## Requirements
- R1: An input value x below 8, where 2^18 is full scale, gives exactly table point x. Table addresses 0..8 are the superfine points.
- R2: For 8 <= x < 2^11, the output is (P[a]*(8-f) + P[a+1]*f + 4) >> 3, with a = 9 + (x >> 3) and f = x & 7. Addresses 9..265 are the fine points.
- R3: For 2^11 <= x < 2^18, the output is (P[a]*(1024-f) + P[a+1]*f + 512) >> 10, with a = 266 + (x >> 10) and f = x & 1023. Addresses 266..522 are the coarse points.
- R4: For 2^18 <= x < 2^18+1024, the output blends P[522] toward the channel ceiling, using weight x-2^18 out of 1024 and the same rounding. Any x >= 2^18+1024 gives the ceiling.
- R5: No pixel output ever exceeds the ceiling of its channel. A rounded result above the ceiling is replaced by the ceiling.
- R6: A pixel sampled with pix_vld high appears at the outputs, with out_vld high, on the third rising edge after the edge that sampled it. out_vld is low in every other cycle.
- R7: cfg_sel selects the register: 0 is the pointer, 1 is data, and 2, 3 and 4 are the blue, green and red ceilings (bits 15:0). A table point takes two data writes. The first write carries the upper 10 bits of red at 29:20, green at 19:10 and blue at 9:0. The second write carries the lower 6 bits of red at 29:24, green at 19:14 and blue at 5:0. The point is stored when the second write arrives.
- R8: The pointer register holds the point address in bits 9:0 and the auto-advance flag in bit 15. With the flag set, the address rises by one after every completed point. With the flag clear, the address does not move.
- R9: Any write to the pointer register makes the next data write the first word of a point. A half-written point is abandoned.
- R10: A data read with cfg_rd returns the first word of the addressed point, then the second word. The second read completes the point and advances the address in the same way a write does. cfg_rdata is combinational from cfg_sel and the current state.
- R11: After reset, out_vld is 0, the pointer register reads 0 and every ceiling reads 16'hFFFF.
- R12: Data writes with the address at 523 or above leave the table unchanged. Data reads at such an address return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_rd | input | 1 | Register read strobe (advances the data read sequence) |
| cfg_sel | input | 3 | Register select: 0 pointer, 1 data, 2/3/4 blue/green/red ceiling |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational) |
| pix_vld | input | 1 | Input pixel valid |
| pix_r | input | 19 | Red input sample, 2^18 = full scale |
| pix_g | input | 19 | Green input sample |
| pix_b | input | 19 | Blue input sample |
| out_vld | output | 1 | Output pixel valid |
| out_r | output | 16 | Red corrected value |
| out_g | output | 16 | Green corrected value |
| out_b | output | 16 | Blue corrected value |

## Verification
The assertions check several properties on every cycle. They check the three-cycle valid delay and that no output rises above the ceiling that was in force. They check that inputs past the top end yield the ceiling itself. On the register side, they check that a pointer write clears the word-pair phase, and that a completed point advances or holds the address as the flag dictates. The scenarios alone show that the right table point and the right weight were picked in each segment and at each segment boundary, and that rounding lands as specified. They also show the bit placement of the two data words, the read-back order, and that writes beyond the table are dropped.

// File: rtl/gamma_pkg.sv
package gamma_pkg;

    // Geometry of the curve and of the pixel samples
    localparam int IN_W     = 19;              // input sample width, 2^(IN_W-1) = full scale
    localparam int VAL_W    = 16;              // stored point / output width
    localparam int NCH      = 3;               // channels: 0 blue, 1 green, 2 red
    localparam int SF_N     = 9;               // superfine points
    localparam int FN_N     = 257;             // fine points
    localparam int CO_N     = 257;             // coarse points
    localparam int FINE_LOG = 7;               // fine span = full scale >> FINE_LOG

    localparam int NENT     = SF_N + FN_N + CO_N;
    localparam int AW       = $clog2(NENT);
    localparam int ENT_W    = NCH * VAL_W;
    localparam int FN_BASE  = SF_N;
    localparam int CO_BASE  = SF_N + FN_N;
    localparam int SEG_BITS = $clog2(CO_N - 1);
    localparam int CSH      = IN_W - 1 - SEG_BITS;             // coarse step log2
    localparam int FSH      = IN_W - 1 - FINE_LOG - SEG_BITS;  // fine step log2
    localparam int WF       = CSH;                             // blend weight width
    localparam int PW       = VAL_W + WF + 1;                  // blend product width
    localparam int LAT      = 3;

    // Register word layout
    localparam int WORD_W   = 32;
    localparam int HI_W     = 10;
    localparam int LO_W     = VAL_W - HI_W;
    localparam int PAIR_W   = NCH * HI_W;
    localparam int AUTO_BIT = 15;

    // Segment thresholds on the input sample
    localparam logic [IN_W-1:0] FS_V     = IN_W'(1) << (IN_W - 1);
    localparam logic [IN_W-1:0] TOP_V    = FS_V + (IN_W'(1) << CSH);
    localparam logic [IN_W-1:0] FN_LIM_V = IN_W'(1) << (IN_W - 1 - FINE_LOG);
    localparam logic [IN_W-1:0] SF_LIM_V = IN_W'(SF_N - 1);

    typedef enum logic [2:0] {
        SEL_PTR  = 3'd0,
        SEL_DATA = 3'd1,
        SEL_MAXB = 3'd2,
        SEL_MAXG = 3'd3,
        SEL_MAXR = 3'd4
    } cfg_sel_e;

    typedef struct packed {
        logic [AW-1:0]               idx;
        logic                        autoinc;
        logic                        phase;
        logic [PAIR_W-1:0]           hold;
        logic [NCH-1:0][VAL_W-1:0]   gmax;
    } reg_st_t;

    typedef struct packed {
        logic [AW-1:0] lo_a;
        logic [AW-1:0] hi_a;
        logic          hi_max;
        logic          sat;
        logic [WF-1:0] f;
    } st1_t;

    typedef struct packed {
        logic [VAL_W-1:0] lo;
        logic [VAL_W-1:0] hi;
        logic             sat;
        logic [WF-1:0]    f;
    } st2_t;

    typedef struct packed {
        st1_t             s1;
        st2_t             s2;
        logic [VAL_W-1:0] y;
    } pipe_t;

    // Bit position of a channel's low part inside the second data word
    function automatic int lo_pos(input int c);
        return (c == 0) ? 0 : c * HI_W + (HI_W - LO_W);
    endfunction

    function automatic logic [WORD_W-1:0] ent_w0(input logic [ENT_W-1:0] e);
        logic [WORD_W-1:0] w;
        w = '0;
        for (int c = 0; c < NCH; c++)
            w[c*HI_W +: HI_W] = e[c*VAL_W + LO_W +: HI_W];
        return w;
    endfunction

    function automatic logic [WORD_W-1:0] ent_w1(input logic [ENT_W-1:0] e);
        logic [WORD_W-1:0] w;
        w = '0;
        for (int c = 0; c < NCH; c++)
            w[lo_pos(c) +: LO_W] = e[c*VAL_W +: LO_W];
        return w;
    endfunction

    function automatic logic [ENT_W-1:0] ent_merge(input logic [PAIR_W-1:0] hi,
                                                   input logic [WORD_W-1:0] w1);
        logic [ENT_W-1:0] e;
        e = '0;
        for (int c = 0; c < NCH; c++) begin
            e[c*VAL_W + LO_W +: HI_W] = hi[c*HI_W +: HI_W];
            e[c*VAL_W +: LO_W]        = w1[lo_pos(c) +: LO_W];
        end
        return e;
    endfunction

endpackage

// File: rtl/gamma_tbl_regs.sv
module gamma_tbl_regs
    import gamma_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cfg_wr,
    input  logic                       cfg_rd,
    input  logic [2:0]                 cfg_sel,
    input  logic [WORD_W-1:0]          cfg_wdata,
    output logic [WORD_W-1:0]          cfg_rdata,
    input  logic [NCH-1:0][AW-1:0]     lo_a_i,
    input  logic [NCH-1:0][AW-1:0]     hi_a_i,
    output logic [NCH-1:0][VAL_W-1:0]  lo_v_o,
    output logic [NCH-1:0][VAL_W-1:0]  hi_v_o,
    output logic [NCH-1:0][VAL_W-1:0]  gmax_o
);

    reg_st_t           st_d, st_q;
    logic              tbl_we;
    logic [ENT_W-1:0]  tbl_wd;
    logic [ENT_W-1:0]  tbl_q [NENT];
    logic              idx_ok;
    logic [ENT_W-1:0]  cur_ent;

    assign idx_ok  = st_q.idx < AW'(NENT);
    assign cur_ent = idx_ok ? tbl_q[st_q.idx] : '0;
    assign gmax_o  = st_q.gmax;

    always_comb begin
        st_d   = st_q;
        tbl_we = 1'b0;
        tbl_wd = ent_merge(st_q.hold, cfg_wdata);
        if (cfg_wr) begin
            case (cfg_sel_e'(cfg_sel))
                SEL_PTR: begin
                    st_d.idx     = cfg_wdata[AW-1:0];
                    st_d.autoinc = cfg_wdata[AUTO_BIT];
                    st_d.phase   = 1'b0;
                end
                SEL_DATA: begin
                    if (!st_q.phase) begin
                        st_d.hold  = cfg_wdata[PAIR_W-1:0];
                        st_d.phase = 1'b1;
                    end else begin
                        st_d.phase = 1'b0;
                        tbl_we     = idx_ok;
                        if (st_q.autoinc) st_d.idx = st_q.idx + 1'b1;
                    end
                end
                SEL_MAXB: st_d.gmax[0] = cfg_wdata[VAL_W-1:0];
                SEL_MAXG: st_d.gmax[1] = cfg_wdata[VAL_W-1:0];
                SEL_MAXR: st_d.gmax[2] = cfg_wdata[VAL_W-1:0];
                default: ;
            endcase
        end else if (cfg_rd && (cfg_sel_e'(cfg_sel) == SEL_DATA)) begin
            st_d.phase = !st_q.phase;
            if (st_q.phase && st_q.autoinc) st_d.idx = st_q.idx + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.idx     <= '0;
            st_q.autoinc <= 1'b0;
            st_q.phase   <= 1'b0;
            st_q.hold    <= '0;
            st_q.gmax    <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        if (tbl_we) tbl_q[st_q.idx] <= tbl_wd;
    end

    always_comb begin
        cfg_rdata = '0;
        case (cfg_sel_e'(cfg_sel))
            SEL_PTR: begin
                cfg_rdata[AW-1:0]     = st_q.idx;
                cfg_rdata[AUTO_BIT]   = st_q.autoinc;
            end
            SEL_DATA: cfg_rdata = st_q.phase ? ent_w1(cur_ent) : ent_w0(cur_ent);
            SEL_MAXB: cfg_rdata[VAL_W-1:0] = st_q.gmax[0];
            SEL_MAXG: cfg_rdata[VAL_W-1:0] = st_q.gmax[1];
            SEL_MAXR: cfg_rdata[VAL_W-1:0] = st_q.gmax[2];
            default: ;
        endcase
    end

    for (genvar c = 0; c < NCH; c++) begin : g_rd
        assign lo_v_o[c] = tbl_q[lo_a_i[c]][c*VAL_W +: VAL_W];
        assign hi_v_o[c] = tbl_q[hi_a_i[c]][c*VAL_W +: VAL_W];
    end

    assert_ptr_clears_phase_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_sel == 3'd0) |=> (st_q.phase == 1'b0));

    assert_autoinc_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_sel == 3'd1 && st_q.phase && st_q.autoinc)
            |=> (st_q.idx == AW'($past(st_q.idx) + 1'b1)));

    assert_no_autoinc_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_sel == 3'd1 && !st_q.autoinc) |=> $stable(st_q.idx));

endmodule

// File: rtl/gamma_seg_pipe.sv
module gamma_seg_pipe
    import gamma_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IN_W-1:0]   x_i,
    input  logic [VAL_W-1:0]  max_i,
    output logic [AW-1:0]     lo_a_o,
    output logic [AW-1:0]     hi_a_o,
    input  logic [VAL_W-1:0]  lo_v_i,
    input  logic [VAL_W-1:0]  hi_v_i,
    output logic [VAL_W-1:0]  y_o
);

    pipe_t           pp_d, pp_q;
    logic [PW-1:0]   blend;
    logic [PW-WF-1:0] blend_sh;

    assign lo_a_o = pp_q.s1.lo_a;
    assign hi_a_o = pp_q.s1.hi_a;
    assign y_o    = pp_q.y;

    always_comb begin
        pp_d = pp_q;

        // stage 1: segment choice, point addresses and weight
        pp_d.s1.sat    = 1'b0;
        pp_d.s1.hi_max = 1'b0;
        pp_d.s1.f      = '0;
        pp_d.s1.lo_a   = AW'(NENT - 1);
        pp_d.s1.hi_a   = AW'(NENT - 1);
        if (x_i >= TOP_V) begin
            pp_d.s1.sat    = 1'b1;
        end else if (x_i >= FS_V) begin
            pp_d.s1.hi_max = 1'b1;
            pp_d.s1.f      = x_i[CSH-1:0];
        end else if (x_i < SF_LIM_V) begin
            pp_d.s1.lo_a   = AW'(x_i);
            pp_d.s1.hi_a   = AW'(x_i);
        end else if (x_i < FN_LIM_V) begin
            pp_d.s1.lo_a   = AW'(FN_BASE) + AW'(x_i >> FSH);
            pp_d.s1.hi_a   = AW'(FN_BASE) + AW'(x_i >> FSH) + 1'b1;
            pp_d.s1.f      = {x_i[FSH-1:0], {(WF-FSH){1'b0}}};
        end else begin
            pp_d.s1.lo_a   = AW'(CO_BASE) + AW'(x_i >> CSH);
            pp_d.s1.hi_a   = AW'(CO_BASE) + AW'(x_i >> CSH) + 1'b1;
            pp_d.s1.f      = x_i[CSH-1:0];
        end

        // stage 2: capture the two neighbouring points
        pp_d.s2.lo  = lo_v_i;
        pp_d.s2.hi  = pp_q.s1.hi_max ? max_i : hi_v_i;
        pp_d.s2.f   = pp_q.s1.f;
        pp_d.s2.sat = pp_q.s1.sat;

        // stage 3: blend, round, limit
        blend    = PW'(pp_q.s2.lo) * (PW'(1) << WF) - PW'(pp_q.s2.lo) * PW'(pp_q.s2.f)
                 + PW'(pp_q.s2.hi) * PW'(pp_q.s2.f) + (PW'(1) << (WF - 1));
        blend_sh = blend[PW-1:WF];
        if (pp_q.s2.sat || (blend_sh > {1'b0, max_i}))
            pp_d.y = max_i;
        else
            pp_d.y = blend_sh[VAL_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pp_q <= '0;
        else        pp_q <= pp_d;
    end

    assert_top_gives_ceiling_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pp_q.s2.sat |=> (y_o == $past(max_i)));

endmodule

// File: rtl/gamma_mseg_lut.sv
module gamma_mseg_lut
    import gamma_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_wr,
    input  logic               cfg_rd,
    input  logic [2:0]         cfg_sel,
    input  logic [31:0]        cfg_wdata,
    output logic [31:0]        cfg_rdata,
    input  logic               pix_vld,
    input  logic [18:0]        pix_r,
    input  logic [18:0]        pix_g,
    input  logic [18:0]        pix_b,
    output logic               out_vld,
    output logic [15:0]        out_r,
    output logic [15:0]        out_g,
    output logic [15:0]        out_b
);

    logic [NCH-1:0][IN_W-1:0]  pix_in;
    logic [NCH-1:0][AW-1:0]    lo_a, hi_a;
    logic [NCH-1:0][VAL_W-1:0] lo_v, hi_v, gmax, y;
    logic [LAT-1:0]            vld_d, vld_q;

    assign pix_in = {pix_r, pix_g, pix_b};

    gamma_tbl_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_rd    (cfg_rd),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .lo_a_i    (lo_a),
        .hi_a_i    (hi_a),
        .lo_v_o    (lo_v),
        .hi_v_o    (hi_v),
        .gmax_o    (gmax)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        gamma_seg_pipe u_pipe (
            .clk    (clk),
            .rst_n  (rst_n),
            .x_i    (pix_in[c]),
            .max_i  (gmax[c]),
            .lo_a_o (lo_a[c]),
            .hi_a_o (hi_a[c]),
            .lo_v_i (lo_v[c]),
            .hi_v_i (hi_v[c]),
            .y_o    (y[c])
        );
    end

    always_comb begin
        vld_d = {vld_q[LAT-2:0], pix_vld};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) vld_q <= '0;
        else        vld_q <= vld_d;
    end

    assign out_vld = vld_q[LAT-1];
    assign out_b   = y[0];
    assign out_g   = y[1];
    assign out_r   = y[2];

    assert_latency_on_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pix_vld |-> ##3 out_vld);

    assert_latency_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_vld |-> ##3 !out_vld);

    assert_out_le_ceiling_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> ((out_b <= $past(gmax[0])) && (out_g <= $past(gmax[1]))
                     && (out_r <= $past(gmax[2]))));

endmodule

// File: tb/sim_gamma_mseg_lut.sv
module sim_gamma_mseg_lut;
    import gamma_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int FSC = 262144;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0, cfg_rd = 1'b0;
    logic [2:0]  cfg_sel = 3'd0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        pix_vld = 1'b0;
    logic [18:0] pix_r = '0, pix_g = '0, pix_b = '0;
    logic        out_vld;
    logic [15:0] out_r, out_g, out_b;

    gamma_mseg_lut u0 (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0, n_bad = 0, cyc = 0;
    int bm [NENT][NCH];
    int mx [NCH];
    int q_b[$], q_g[$], q_r[$], q_t[$];
    string q_tag[$];

    always @(posedge clk) cyc++;

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
        end
    endtask

    function automatic int tv(int i, int ch);
        if (i < 9)   return 11 * i + ch;
        if (i < 266) return 200 + 40 * (i - 9) + 7 * ch;
        return 255 * (i - 266) + 3 * ch;
    endfunction

    function automatic logic [31:0] enc_hi(int r, int g, int b);
        return {2'b0, 10'(r >> 6), 10'(g >> 6), 10'(b >> 6)};
    endfunction

    function automatic logic [31:0] enc_lo(int r, int g, int b);
        return {2'b0, 6'(r & 63), 4'b0, 6'(g & 63), 8'b0, 6'(b & 63)};
    endfunction

    function automatic int exp_px(int ch, int x);
        int lo, hi, f, y, i;
        if (x >= FSC + 1024) return mx[ch];
        if (x >= FSC) begin
            lo = bm[NENT-1][ch]; hi = mx[ch]; f = x - FSC;
            y = (lo * (1024 - f) + hi * f + 512) / 1024;
        end else if (x < 8) begin
            y = bm[x][ch];
        end else if (x < 2048) begin
            i = x / 8; f = x % 8;
            lo = bm[9 + i][ch]; hi = bm[10 + i][ch];
            y = (lo * (8 - f) + hi * f + 4) / 8;
        end else begin
            i = x / 1024; f = x % 1024;
            lo = bm[266 + i][ch]; hi = bm[267 + i][ch];
            y = (lo * (1024 - f) + hi * f + 512) / 1024;
        end
        return (y > mx[ch]) ? mx[ch] : y;
    endfunction

    task automatic cfg_write(int sel, logic [31:0] d);
        @(negedge clk);
        cfg_sel = 3'(sel); cfg_wdata = d; cfg_wr = 1'b1;
        @(posedge clk); #1 cfg_wr = 1'b0;
    endtask

    task automatic cfg_read(int sel, output logic [31:0] d);
        @(negedge clk);
        cfg_sel = 3'(sel); cfg_rd = 1'b1;
        #1 d = cfg_rdata;
        @(posedge clk); #1 cfg_rd = 1'b0;
    endtask

    task automatic cfg_peek(int sel, output logic [31:0] d);
        @(negedge clk);
        cfg_sel = 3'(sel);
        #1 d = cfg_rdata;
    endtask

    task automatic put_entry(int r, int g, int b);
        cfg_write(1, enc_hi(r, g, b));
        cfg_write(1, enc_lo(r, g, b));
    endtask

    task automatic px(int r, int g, int b, string tag);
        @(negedge clk);
        pix_vld = 1'b1; pix_r = 19'(r); pix_g = 19'(g); pix_b = 19'(b);
        q_r.push_back(exp_px(2, r)); q_g.push_back(exp_px(1, g));
        q_b.push_back(exp_px(0, b)); q_t.push_back(cyc); q_tag.push_back(tag);
    endtask

    task automatic px_idle();
        @(negedge clk);
        pix_vld = 1'b0;
    endtask

    // monitor: pop expected items as results emerge
    always @(negedge clk) begin
        if (rst_n && out_vld) begin
            if (q_t.size() == 0) begin
                n_chk++; n_bad++;
                $display("FAIL R6: actual out_vld=1 expected no pending pixel");
            end else begin
                automatic string tg = q_tag.pop_front();
                chk({tg, " red"},   int'(out_r), q_r.pop_front());
                chk({tg, " green"}, int'(out_g), q_g.pop_front());
                chk({tg, " blue"},  int'(out_b), q_b.pop_front());
                chk("R6 latency", cyc - q_t.pop_front(), 3);
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        int seed;
        int lst[15];
        for (int c = 0; c < NCH; c++) mx[c] = 65535;
        for (int i = 0; i < NENT; i++)
            for (int c = 0; c < NCH; c++) bm[i][c] = tv(i, c);

        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R11 reset state
        cfg_peek(0, rd);  chk("R11 pointer", int'(rd), 0);
        cfg_peek(2, rd);  chk("R11 blue ceiling", int'(rd), 65535);
        cfg_peek(4, rd);  chk("R11 red ceiling", int'(rd), 65535);
        chk("R11 out_vld", int'(out_vld), 0);

        // R7 / R8 fill the whole table with auto-advance
        cfg_write(0, 32'h0000_8000);
        for (int i = 0; i < NENT; i++) put_entry(bm[i][2], bm[i][1], bm[i][0]);
        cfg_peek(0, rd);  chk("R8 pointer after fill", int'(rd), 32'h8000 | NENT);

        // R10 read back two points in word order
        cfg_write(0, 32'h0000_8000 | 266);
        for (int i = 266; i < 268; i++) begin
            cfg_read(1, rd); chk("R10 word0", int'(rd), int'(enc_hi(bm[i][2], bm[i][1], bm[i][0])));
            cfg_read(1, rd); chk("R10 word1", int'(rd), int'(enc_lo(bm[i][2], bm[i][1], bm[i][0])));
        end
        cfg_peek(0, rd);  chk("R10 pointer advanced", int'(rd), 32'h8000 | 268);

        // R8 without the flag the address holds
        cfg_write(0, 5);
        put_entry(1000, 2000, 3000);
        cfg_peek(0, rd);  chk("R8 hold", int'(rd), 5);
        cfg_read(1, rd);  chk("R7 word0 fields", int'(rd), int'(enc_hi(1000, 2000, 3000)));
        cfg_read(1, rd);  chk("R7 word1 fields", int'(rd), int'(enc_lo(1000, 2000, 3000)));
        cfg_peek(0, rd);  chk("R8 hold after read", int'(rd), 5);
        put_entry(bm[5][2], bm[5][1], bm[5][0]);

        // R9 a pointer write abandons a half point
        cfg_write(0, 32'h0000_8000 | 7);
        cfg_write(1, 32'h3FFF_FFFF);
        cfg_write(0, 32'h0000_8000 | 7);
        put_entry(bm[7][2], bm[7][1], bm[7][0]);
        cfg_write(0, 7);
        cfg_read(1, rd);  chk("R9 word0", int'(rd), int'(enc_hi(bm[7][2], bm[7][1], bm[7][0])));
        cfg_read(1, rd);  chk("R9 word1", int'(rd), int'(enc_lo(bm[7][2], bm[7][1], bm[7][0])));

        // R12 beyond the table
        cfg_write(0, 600);
        put_entry(9, 9, 9);
        cfg_read(1, rd);  chk("R12 read out of range", int'(rd), 0);
        cfg_write(0, NENT - 1);
        cfg_read(1, rd);  chk("R12 last point intact", int'(rd),
                              int'(enc_hi(bm[NENT-1][2], bm[NENT-1][1], bm[NENT-1][0])));

        // segment corners
        lst = '{0, 3, 7, 8, 9, 100, 2047, 2048, 5000, 123457, 262143,
                FSC, FSC + 512, FSC + 1023, FSC + 1024};
        for (int i = 0; i < 15; i++) px(lst[i], lst[(i + 5) % 15], lst[(i + 10) % 15], "R1-4 corner");
        px(524287, 1, 1024, "R4 top");
        px_idle();
        repeat (6) @(negedge clk);

        // mixed stream with gaps (R6)
        seed = 32'h1234_5678;
        for (int i = 0; i < 300; i++) begin
            int a, b, c;
            seed = seed * 1103515245 + 12345; a = (seed >>> 8) & 19'h7FFFF; a = a >> ((seed >>> 3) & 15);
            seed = seed * 1103515245 + 12345; b = (seed >>> 8) & 19'h7FFFF; b = b >> ((seed >>> 3) & 15);
            seed = seed * 1103515245 + 12345; c = (seed >>> 8) & 19'h7FFFF; c = c >> ((seed >>> 3) & 15);
            px(a, b, c, "R2 R3 mixed");
            if ((seed & 7) == 0) px_idle();
        end
        px_idle();
        repeat (6) @(negedge clk);

        // R5 lowered ceilings
        cfg_write(4, 30000); mx[2] = 30000;
        cfg_write(3, 100);   mx[1] = 100;
        cfg_peek(4, rd);  chk("R5 red ceiling reads back", int'(rd), 30000);
        for (int i = 0; i < 12; i++)
            px(i * 40000 + 17, i * 190 + 3, i * 20000, "R5 ceiling");
        px(FSC + 300, FSC + 300, FSC + 300, "R5 top blend");
        px_idle();
        repeat (8) @(negedge clk);

        chk("R6 all results seen", q_t.size(), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule